// File: doc/BRIEF.md
# I2C Bus Status and Error Flags

This block holds the error and event flags of an I2C controller. It watches the SCL and SDA lines, brings them into the clock domain through a synchronizer, and finds Start conditions, Stop conditions and rising SCL edges. It also takes strobes from the rest of the controller. These strobes say whether the controller is currently driving a bit as master, what value it drives, and when an address byte has been fully received. From these inputs the block keeps three flags: arbitration lost, misplaced bus condition, and general call seen.

The flags appear in an 8-bit status value. A read strobe clears the two error flags. The general-call flag survives a read and is cleared only by a Stop. The block also keeps the master/slave mode bit, which software requests and which drops to slave by itself when arbitration is lost. Its outputs are an interrupt request gated by an enable, and a request to the clock-stretching logic to let go of SCL while an error flag is up. When the peripheral enable is low, every flag and the mode bit are held at zero.

Top module: `i2c_bus_flags`

## Requirements
- R1: `sr2` bit 2 (arbitration lost) is set on a synchronized rising SCL edge when master mode is active, `mst_tx` is 1, `drive_bit` is 1 and the synchronized SDA is 0. It is not set when `mst_tx` is 0, which is the case while the master receives and the acknowledge bit is on the bus.
- R2: The edge that sets arbitration lost also clears `master_mode`, even when `master_req` is pulsed in the same cycle. `master_req` sets the mode and `master_rel` clears it.
- R3: `sr2` bit 1 (bus error) is set when a Start (SDA falls while SCL is high) or a Stop (SDA rises while SCL is high) is seen after 2 to 9 SCL rises into the current frame slot. A frame slot is 8 data bits plus the acknowledge, and the count restarts at 1 after the 9th rise. A condition seen at slot position 0 or 1 leaves the flag clear.
- R4: A one-cycle `sr2_read` pulse clears bits 2 and 1. A flag that is set in the same cycle as the read stays set.
- R5: `sr2` bit 0 (general call) is set on an `addr_done` pulse when `addr_byte` is 00h and `engc` is 1. It is not set if `engc` is 0 or the address byte is nonzero.
- R6: The general-call flag is cleared by a Stop and is not cleared by `sr2_read`.
- R7: While `pe` is 0, all flags and `master_mode` are 0 and no event can set them.
- R8: `irq` is 1 exactly when `ite` is 1 and either bit 2 or bit 1 is set. The general-call flag never raises `irq`.
- R9: `scl_release` is 1 while bit 2 or bit 1 is set, and it falls only after a read or after `pe` goes low.
- R10: `sr2` is 00h after reset, and bits 7 to 3 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| pe | input | 1 | Peripheral enable |
| ite | input | 1 | Interrupt enable |
| engc | input | 1 | General call enable |
| mst_tx | input | 1 | Master is driving the current bit |
| drive_bit | input | 1 | Value being driven on SDA |
| master_req | input | 1 | Pulse: enter master mode |
| master_rel | input | 1 | Pulse: return to slave mode |
| addr_done | input | 1 | Pulse: address byte complete |
| addr_byte | input | 8 | Received address byte |
| sr2_read | input | 1 | Pulse: status register read |
| sr2 | output | 8 | Status value: bit 2 arbitration lost, bit 1 bus error, bit 0 general call |
| irq | output | 1 | Interrupt request |
| master_mode | output | 1 | 1 = master, 0 = slave |
| scl_release | output | 1 | Do not hold SCL low |

## Verification
A status read and a new arbitration loss can fall in the same clock cycle. In that case the read clears the flag while the hardware sets it again. The bench provokes this by counting the two synchronizer stages and the edge-detect register after it raises SCL. It then asserts `sr2_read` in exactly the cycle in which the synchronized rising edge reaches the flag logic. The outcome is judged correct only if arbitration lost is still 1 afterwards, because the new event must not be lost to the read.

// File: rtl/i2c_flags_pkg.sv
package i2c_flags_pkg;

    localparam int ARLO_POS = 2;
    localparam int BERR_POS = 1;
    localparam int GCAL_POS = 0;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic sda_lvl;
    } bus_evt_t;

    typedef struct packed {
        logic arlo;
        logic berr;
        logic gcal;
        logic master;
    } flag_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_flags_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;
    logic  scl_s, sda_s;

    assign scl_s = q.scl_sh[STAGES-1];
    assign sda_s = q.sda_sh[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[STAGES-2:0], scl_in};
        d.sda_sh   = {q.sda_sh[STAGES-2:0], sda_in};
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    always_comb begin
        evt.start    = q.scl_prev & scl_s & q.sda_prev & ~sda_s;
        evt.stop     = q.scl_prev & scl_s & ~q.sda_prev & sda_s;
        evt.scl_rise = ~q.scl_prev & scl_s;
        evt.sda_lvl  = sda_s;
    end

endmodule

// File: rtl/i2c_frame_pos.sv
module i2c_frame_pos
    import i2c_flags_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pe,
    input  bus_evt_t evt,
    output logic     misplaced
);

    localparam int SLOTS = BYTE_BITS + 1;
    localparam int CW    = $clog2(SLOTS + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } pos_t;

    pos_t q, d;

    always_comb begin
        d = q;
        if (!pe) begin
            d = '0;
        end else if (evt.start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
        end else if (evt.stop) begin
            d = '0;
        end else if (evt.scl_rise && q.busy) begin
            d.cnt = (q.cnt == CW'(SLOTS)) ? CW'(1) : q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign misplaced = pe & q.busy & (q.cnt >= CW'(2)) & (evt.start | evt.stop);

endmodule

// File: rtl/i2c_flag_core.sv
module i2c_flag_core
    import i2c_flags_pkg::*;
#(
    parameter int          AW      = 8,
    parameter logic [AW-1:0] GC_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pe,
    input  logic          engc,
    input  bus_evt_t      evt,
    input  logic          misplaced,
    input  logic          mst_tx,
    input  logic          drive_bit,
    input  logic          master_req,
    input  logic          master_rel,
    input  logic          addr_done,
    input  logic [AW-1:0] addr_byte,
    input  logic          sr2_read,
    output flag_state_t   st
);

    flag_state_t q, d;
    logic        arb_lost, gc_hit;

    assign arb_lost = q.master & mst_tx & drive_bit & evt.scl_rise & ~evt.sda_lvl;
    assign gc_hit   = addr_done & engc & (addr_byte == GC_ADDR);

    always_comb begin
        d = q;
        if (sr2_read) begin
            d.arlo = 1'b0;
            d.berr = 1'b0;
        end
        if (arb_lost)   d.arlo = 1'b1;
        if (misplaced)  d.berr = 1'b1;
        if (evt.stop)   d.gcal = 1'b0;
        if (gc_hit)     d.gcal = 1'b1;
        if (master_rel) d.master = 1'b0;
        if (master_req) d.master = 1'b1;
        if (arb_lost)   d.master = 1'b0;
        if (!pe)        d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st = q;

endmodule

// File: rtl/i2c_bus_flags.sv
module i2c_bus_flags
    import i2c_flags_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_BITS   = 8,
    parameter int SR_W        = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 pe,
    input  logic                 ite,
    input  logic                 engc,
    input  logic                 mst_tx,
    input  logic                 drive_bit,
    input  logic                 master_req,
    input  logic                 master_rel,
    input  logic                 addr_done,
    input  logic [BYTE_BITS-1:0] addr_byte,
    input  logic                 sr2_read,
    output logic [SR_W-1:0]      sr2,
    output logic                 irq,
    output logic                 master_mode,
    output logic                 scl_release
);

    bus_evt_t    evt;
    logic        misplaced;
    flag_state_t st;
    logic        stop_seen;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_frame_pos #(.BYTE_BITS(BYTE_BITS)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .pe        (pe),
        .evt       (evt),
        .misplaced (misplaced)
    );

    i2c_flag_core #(.AW(BYTE_BITS), .GC_ADDR('0)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .pe         (pe),
        .engc       (engc),
        .evt        (evt),
        .misplaced  (misplaced),
        .mst_tx     (mst_tx),
        .drive_bit  (drive_bit),
        .master_req (master_req),
        .master_rel (master_rel),
        .addr_done  (addr_done),
        .addr_byte  (addr_byte),
        .sr2_read   (sr2_read),
        .st         (st)
    );

    assign stop_seen = evt.stop;

    always_comb begin
        sr2           = '0;
        sr2[ARLO_POS] = st.arlo;
        sr2[BERR_POS] = st.berr;
        sr2[GCAL_POS] = st.gcal;
    end

    assign irq         = ite & (st.arlo | st.berr);
    assign scl_release = st.arlo | st.berr;
    assign master_mode = st.master;

endmodule

// File: rtl/i2c_bus_flags_chk.sv
module i2c_bus_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pe,
    input logic       ite,
    input logic       sr2_read,
    input logic       stop_seen,
    input logic [7:0] sr2,
    input logic       irq,
    input logic       master_mode,
    input logic       scl_release
);

    p_arlo_needs_master_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr2[2]) |-> $past(master_mode));

    p_arlo_drops_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr2[2]) |-> !master_mode);

    p_gcal_kept_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pe && sr2[0] && !stop_seen) |=> sr2[0]);

    p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pe |=> (sr2[2:0] == 3'b000) && !master_mode);

    p_berr_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sr2[1]) && ite) |-> irq);

    p_release_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_release) |-> ($past(sr2_read) || !$past(pe)));

endmodule

bind i2c_bus_flags i2c_bus_flags_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pe          (pe),
    .ite         (ite),
    .sr2_read    (sr2_read),
    .stop_seen   (stop_seen),
    .sr2         (sr2),
    .irq         (irq),
    .master_mode (master_mode),
    .scl_release (scl_release)
);

// File: tb/i2c_bus_flags_bench.sv
`timescale 1ns/1ps
module i2c_bus_flags_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       pe = 1'b0, ite = 1'b0, engc = 1'b0;
    logic       mst_tx = 1'b0, drive_bit = 1'b0;
    logic       master_req = 1'b0, master_rel = 1'b0;
    logic       addr_done = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       sr2_read = 1'b0;
    logic [7:0] sr2;
    logic       irq, master_mode, scl_release;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    i2c_bus_flags u_i2c_bus_flags (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .pe(pe), .ite(ite), .engc(engc), .mst_tx(mst_tx), .drive_bit(drive_bit),
        .master_req(master_req), .master_rel(master_rel), .addr_done(addr_done),
        .addr_byte(addr_byte), .sr2_read(sr2_read), .sr2(sr2), .irq(irq),
        .master_mode(master_mode), .scl_release(scl_release)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic line(input logic c, input logic s);
        scl_in = c;
        sda_in = s;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_read();
        sr2_read = 1'b1;
        @(negedge clk);
        sr2_read = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_master();
        master_req = 1'b1;
        @(negedge clk);
        master_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_addr(input logic [7:0] a);
        addr_byte = a;
        addr_done = 1'b1;
        @(negedge clk);
        addr_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_idle();
        pe = 1'b0; mst_tx = 1'b0; drive_bit = 1'b0; engc = 1'b0;
        line(1'b1, 1'b1);
        pe = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_start();
        line(1'b1, 1'b1);
        line(1'b1, 1'b0);
        line(1'b0, 1'b0);
    endtask

    task automatic send_bit(input logic b);
        line(1'b0, b);
        line(1'b1, b);
        line(1'b0, b);
    endtask

    task automatic t_reset();
        chk(sr2, 8'h00, "R10 reset value");
        chk({7'b0, irq}, 8'h00, "R8 reset irq");
        chk({7'b0, master_mode}, 8'h00, "R2 reset mode");
        chk({7'b0, scl_release}, 8'h00, "R9 reset release");
    endtask

    task automatic t_arb_loss();
        bus_idle();
        ite = 1'b1;
        pulse_master();
        chk({7'b0, master_mode}, 8'h01, "R2 master_req sets mode");
        do_start();
        mst_tx = 1'b1; drive_bit = 1'b1;
        line(1'b0, 1'b0);
        line(1'b1, 1'b0);
        chk(sr2, 8'h04, "R1 arbitration lost bit 2");
        chk({7'b0, master_mode}, 8'h00, "R2 forced to slave");
        chk({7'b0, irq}, 8'h01, "R8 irq on arlo");
        chk({7'b0, scl_release}, 8'h01, "R9 release while arlo");
        pulse_read();
        chk(sr2, 8'h00, "R4 read clears arlo");
        chk({7'b0, scl_release}, 8'h00, "R9 release drops after read");
        chk({7'b0, irq}, 8'h00, "R8 irq drops after read");
    endtask

    task automatic t_ack_no_check();
        bus_idle();
        pulse_master();
        do_start();
        mst_tx = 1'b0; drive_bit = 1'b1;
        line(1'b0, 1'b0);
        line(1'b1, 1'b0);
        chk(sr2, 8'h00, "R1 no arbitration check when receiving");
        chk({7'b0, master_mode}, 8'h01, "R2 mode kept without loss");
    endtask

    task automatic t_misplaced();
        bus_idle();
        ite = 1'b1;
        do_start();
        send_bit(1'b1);
        line(1'b0, 1'b0);
        line(1'b1, 1'b0);
        line(1'b1, 1'b1);
        chk(sr2, 8'h02, "R3 stop at slot position 2 sets berr");
        chk({7'b0, irq}, 8'h01, "R8 irq on berr");
        chk({7'b0, scl_release}, 8'h01, "R9 release while berr");
        ite = 1'b0;
        @(negedge clk);
        chk({7'b0, irq}, 8'h00, "R8 irq masked by ite");
        pulse_read();
        chk(sr2, 8'h00, "R4 read clears berr");
    endtask

    task automatic t_legal();
        bus_idle();
        do_start();
        for (int i = 0; i < 9; i++) send_bit(1'b0);
        line(1'b0, 1'b0);
        line(1'b1, 1'b0);
        line(1'b1, 1'b1);
        chk(sr2, 8'h00, "R3 stop after acknowledge is legal");
        do_start();
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        line(1'b0, 1'b1);
        line(1'b1, 1'b1);
        line(1'b1, 1'b0);
        chk(sr2, 8'h00, "R3 repeated start after acknowledge is legal");
    endtask

    task automatic t_general_call();
        bus_idle();
        ite = 1'b1;
        engc = 1'b1;
        do_start();
        for (int i = 0; i < 9; i++) send_bit(1'b0);
        pulse_addr(8'h00);
        chk(sr2, 8'h01, "R5 general call sets bit 0");
        chk({7'b0, irq}, 8'h00, "R8 general call gives no irq");
        pulse_read();
        chk(sr2, 8'h01, "R6 read keeps general call");
        line(1'b0, 1'b0);
        line(1'b1, 1'b0);
        line(1'b1, 1'b1);
        chk(sr2, 8'h00, "R6 stop clears general call");
        engc = 1'b0;
        pulse_addr(8'h00);
        chk(sr2, 8'h00, "R5 ignored when engc is 0");
        engc = 1'b1;
        pulse_addr(8'hA0);
        chk(sr2, 8'h00, "R5 ignored for nonzero address");
    endtask

    task automatic t_pe_disable();
        bus_idle();
        ite = 1'b1;
        engc = 1'b1;
        pulse_master();
        do_start();
        mst_tx = 1'b1; drive_bit = 1'b1;
        line(1'b0, 1'b0);
        line(1'b1, 1'b0);
        pulse_addr(8'h00);
        chk(sr2, 8'h05, "R7 setup flags before disable");
        pe = 1'b0;
        repeat (2) @(negedge clk);
        chk(sr2, 8'h00, "R7 disable clears flags");
        chk({7'b0, irq}, 8'h00, "R7 irq low while disabled");
        pulse_master();
        chk({7'b0, master_mode}, 8'h00, "R7 mode blocked while disabled");
        pulse_addr(8'h00);
        chk(sr2, 8'h00, "R7 general call blocked while disabled");
        pe = 1'b1;
    endtask

    task automatic t_read_collision();
        bus_idle();
        pulse_master();
        do_start();
        mst_tx = 1'b1; drive_bit = 1'b1;
        line(1'b0, 1'b0);
        scl_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sr2_read = 1'b1;
        @(negedge clk);
        sr2_read = 1'b0;
        chk({7'b0, sr2[2]}, 8'h01, "R4 set wins over read in same cycle");
        @(negedge clk);
        pulse_read();
        chk(sr2, 8'h00, "R4 later read clears");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arb_loss();
        t_ack_no_check();
        t_misplaced();
        t_legal();
        t_general_call();
        t_pe_disable();
        t_read_collision();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule